// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a parallel host bus and the internal program/erase engine of a NOR-style flash device. Each bus write cycle carries an address, a 16-bit data word and a byte/word mode flag. The sequencer decodes the command code, walks the multi-cycle command sequences, and issues a launch request to the engine only after the full sequence has been accepted. That request carries the operation kind, the address, the data and the buffer length. A busy counter stands in for the engine's program and erase time.

The most involved sequence is the buffered write. After the opening code, the next cycle gives a count argument n. Exactly n+1 data cycles then follow, and each one is streamed out on a buffer-write port with its index. The write after them must be the confirm code, otherwise the sequence is aborted. The block also holds one lock bit per block, checks those locks against the protect input, records sticky error flags in a status byte, and accepts suspend and resume while an operation runs. It chooses what a read returns: array data, the status byte, lock identifier data, query data or buffer-availability status. While the engine is busy, reads are masked to the ready bit.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the read path returns array data, `rd_oe` is all ones, `busy` and `op_start` are low, every lock bit is clear and the status byte reads 80h.
- R2: In word mode, bits 15..8 of a command write are ignored. For example, 3470h acts as 70h and AB98h acts as 98h.
- R3: Codes outside the command set are ignored in the idle state and leave the read mode and the status unchanged. This includes 33h, C5h, 01h, and D0h or B0h when no operation is running.
- R4: 40h and 10h both open a single program. The next write launches `op_start` with `op_kind`=0, and `op_addr`/`op_data` taken from that write. `op_start` is high in the cycle after that write.
- R5: E8h opens a buffered write at its address, and the following write is the count n. Exactly n+1 data writes then appear on `buf_we` with `buf_idx` running 0..n. A D0h write after them launches `op_kind`=1 with `op_len`=n. In word mode n may be 0..15 (the full 16 bits are checked); in byte mode n may be 0..31 (low byte).
- R6: The buffered write is aborted without a launch when the write after the data cycles is not D0h, or when the count is out of range. An abort sets status bits 5 and 4, so the status byte reads B0h.
- R7: 20h followed by D0h launches an erase (`op_kind`=2) at the D0h address. Any other second code sets status bits 5 and 4 and launches nothing.
- R8: 60h then 01h sets the lock bit of the addressed block; the block is the top BLK_W address bits. With `wp_n` high, a program or erase aimed at a locked block launches nothing and sets status bit 1 together with bit 4 (program, 92h) or bit 5 (erase, A2h). With `wp_n` low, the lock is not enforced.
- R9: 60h then D0h clears every lock bit in one cycle.
- R10: While an operation runs and is not suspended, `rd_oe` is 0080h and `rd_data` is 0000h, which shows the ready bit low. Program lasts PROG_CYC cycles and erase lasts ERASE_CYC cycles. After that the status byte reads 80h.
- R11: B0h during a running program or buffered write sets status bit 2; during an erase it sets bit 6. Either way the ready bit reads 1 and the busy time stops. D0h resumes the operation.
- R12: Error bits stay set until 50h is written, which clears them and selects array reads.
- R13: FFh selects array reads, 70h the status byte, 90h lock identifier reads (bit 0 = lock bit of the block at `rd_addr`), 98h query data, and E8h the buffer status (bit 7 = buffer free).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Protect input; high enforces the lock bits |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | 16 | Bus write data |
| byte_mode | input | 1 | 1 = byte mode, 0 = word mode |
| rd_addr | input | ADDR_W | Read address (selects the block for identifier reads) |
| array_rdata | input | 16 | Data from the cell array |
| query_rdata | input | 16 | Data from the query table |
| rd_data | output | 16 | Read data |
| rd_oe | output | 16 | Per-bit output enable |
| op_start | output | 1 | One-cycle launch request to the engine |
| op_kind | output | 2 | 0 program, 1 buffered write, 2 erase |
| op_addr | output | ADDR_W | Target address of the launch |
| op_data | output | 16 | Data of a single program |
| op_len | output | IDX_W | Buffer count n of a buffered write |
| buf_we | output | 1 | Buffer data write strobe |
| buf_idx | output | IDX_W | Buffer slot index |
| buf_wdata | output | 16 | Buffer data |
| busy | output | 1 | Engine operation in progress (held while suspended) |

## Verification
A wrong sequence state surfaces on the first write after the slip. A launch arrives on `op_start` one cycle early or late, or fails to arrive, and the status byte then holds B0h instead of the busy-masked zero. A wrong buffer count shows up as a missing or extra `buf_we` pulse, or as a `buf_idx` gap, before the confirm write. A stray lock or error bit becomes visible on the next identifier or status read. A timer that does not freeze under suspend shows up as `busy` dropping during the suspended window.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PROG_DATA, SQ_ERASE_CONF, SQ_LOCK_CONF,
    SQ_BUF_COUNT, SQ_BUF_DATA, SQ_BUF_CONF
  } seq_e;

  typedef enum logic [2:0] {
    RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY, RM_XSTAT
  } rmode_e;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0, OP_BUF = 2'd1, OP_ERASE = 2'd2
  } op_e;

  localparam logic [7:0] C_RD_ARRAY   = 8'hFF;
  localparam logic [7:0] C_RD_STATUS  = 8'h70;
  localparam logic [7:0] C_CLR_STATUS = 8'h50;
  localparam logic [7:0] C_RD_IDENT   = 8'h90;
  localparam logic [7:0] C_RD_QUERY   = 8'h98;
  localparam logic [7:0] C_PROG_A     = 8'h40;
  localparam logic [7:0] C_PROG_B     = 8'h10;
  localparam logic [7:0] C_ERASE      = 8'h20;
  localparam logic [7:0] C_BUF        = 8'hE8;
  localparam logic [7:0] C_CONFIRM    = 8'hD0;
  localparam logic [7:0] C_SUSPEND    = 8'hB0;
  localparam logic [7:0] C_LOCK       = 8'h60;
  localparam logic [7:0] C_LOCK_SET   = 8'h01;

endpackage

// File: rtl/fcs_busy_timer.sv
module fcs_busy_timer #(
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_erase,
  input  logic hold,
  output logic busy
);
  localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_erase ? CNT_W'(ERASE_CYC) : CNT_W'(PROG_CYC);
    else if ((cnt_q != '0) && !hold)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  AST_NO_RELOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R10
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold && !load) |=> busy); // R11

endmodule

// File: rtl/fcs_lock_bank.sv
module fcs_lock_bank #(
  parameter  int BLK_W   = 2,
  localparam int NUM_BLK = 1 << BLK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [BLK_W-1:0] set_blk,
  input  logic             clr_all,
  input  logic [BLK_W-1:0] chk_blk,
  output logic             chk_locked,
  input  logic [BLK_W-1:0] rd_blk,
  output logic             rd_locked
);
  logic [NUM_BLK-1:0] lock_q, lock_d;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    always_comb begin
      lock_d[b] = lock_q[b];
      if (clr_all)                              lock_d[b] = 1'b0;
      else if (set_en && set_blk == BLK_W'(b))  lock_d[b] = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q[b] <= 1'b0;
      else        lock_q[b] <= lock_d[b];
    end
  end

  assign chk_locked = lock_q[chk_blk];
  assign rd_locked  = lock_q[rd_blk];

  AST_LOCK_BY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q != $past(lock_q)) |-> $past(set_en || clr_all)); // R8
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_all) |-> (lock_q == '0)); // R9

endmodule

// File: rtl/fcs_buf_ctrl.sv
module fcs_buf_ctrl #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] n_in,
  input  logic             step,
  input  logic [15:0]      din,
  output logic             last,
  output logic [IDX_W-1:0] n_out,
  output logic             we,
  output logic [IDX_W-1:0] widx,
  output logic [15:0]      wdata
);
  logic [IDX_W-1:0] cnt_q, cnt_d, n_q, n_d, widx_q, widx_d;
  logic             we_q, we_d;
  logic [15:0]      wdata_q, wdata_d;

  always_comb begin
    cnt_d   = cnt_q;
    n_d     = n_q;
    we_d    = step;
    widx_d  = widx_q;
    wdata_d = wdata_q;
    if (start) begin
      cnt_d = '0;
      n_d   = n_in;
    end else if (step) begin
      cnt_d   = cnt_q + 1'b1;
      widx_d  = cnt_q;
      wdata_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      n_q     <= '0;
      we_q    <= 1'b0;
      widx_q  <= '0;
      wdata_q <= '0;
    end else begin
      cnt_q   <= cnt_d;
      n_q     <= n_d;
      we_q    <= we_d;
      widx_q  <= widx_d;
      wdata_q <= wdata_d;
    end
  end

  assign last  = (cnt_q == n_q);
  assign n_out = n_q;
  assign we    = we_q;
  assign widx  = widx_q;
  assign wdata = wdata_q;

  AST_BUF_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (widx <= n_q)); // R5
  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (cnt_q <= n_q)); // R5

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter  int ADDR_W    = 12,
  parameter  int BLK_W     = 2,
  parameter  int BUF_WORDS = 16,
  parameter  int PROG_CYC  = 8,
  parameter  int ERASE_CYC = 20,
  localparam int IDX_W     = $clog2(2 * BUF_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [15:0]       array_rdata,
  input  logic [15:0]       query_rdata,
  output logic [15:0]       rd_data,
  output logic [15:0]       rd_oe,
  output logic              op_start,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [15:0]       op_data,
  output logic [IDX_W-1:0]  op_len,
  output logic              buf_we,
  output logic [IDX_W-1:0]  buf_idx,
  output logic [15:0]       buf_wdata,
  output logic              busy
);
  localparam logic [15:0] MAX_N_WORD = 16'(BUF_WORDS - 1);
  localparam logic [15:0] MAX_N_BYTE = 16'(2 * BUF_WORDS - 1);

  seq_e   seq_q, seq_d;
  rmode_e rmode_q, rmode_d;
  op_e    kind_q, kind_d, launch_kind;
  logic   err_prog_q, err_prog_d, err_erase_q, err_erase_d, err_lock_q, err_lock_d;
  logic   susp_q, susp_d;
  logic   start_q;
  logic [ADDR_W-1:0] addr_q, addr_d, opaddr_q, opaddr_d;
  logic [15:0]       opdata_q, opdata_d;

  logic        launch, buf_start, buf_step, buf_last, lock_set, lock_clr;
  logic        chk_locked, rd_locked, busy_w, running, lock_fail;
  logic [BLK_W-1:0]  chk_blk;
  logic [IDX_W-1:0]  buf_n;
  logic [7:0]  cmd, sr;
  logic [15:0] cnt_val, cnt_max;

  assign cmd     = wr_data[7:0];
  assign cnt_val = byte_mode ? {8'h00, wr_data[7:0]} : wr_data;
  assign cnt_max = byte_mode ? MAX_N_BYTE : MAX_N_WORD;
  assign running = busy_w && !susp_q;
  assign chk_blk = (seq_q == SQ_BUF_CONF) ? addr_q[ADDR_W-1 -: BLK_W]
                                          : wr_addr[ADDR_W-1 -: BLK_W];
  assign lock_fail = chk_locked && wp_n;

  always_comb begin
    seq_d = seq_q;  rmode_d = rmode_q;  kind_d = kind_q;  susp_d = susp_q;
    err_prog_d = err_prog_q;  err_erase_d = err_erase_q;  err_lock_d = err_lock_q;
    addr_d = addr_q;  opaddr_d = opaddr_q;  opdata_d = opdata_q;
    launch = 1'b0;  launch_kind = OP_PROG;
    buf_start = 1'b0;  buf_step = 1'b0;  lock_set = 1'b0;  lock_clr = 1'b0;
    if (wr_en) begin
      if (running) begin
        if (cmd == C_SUSPEND) begin
          susp_d  = 1'b1;
          rmode_d = RM_STATUS;
        end else if (cmd == C_RD_STATUS) begin
          rmode_d = RM_STATUS;
        end
      end else if (susp_q) begin
        case (cmd)
          C_CONFIRM:    begin susp_d = 1'b0; rmode_d = RM_STATUS; end
          C_RD_ARRAY:   rmode_d = RM_ARRAY;
          C_RD_STATUS:  rmode_d = RM_STATUS;
          C_RD_IDENT:   rmode_d = RM_IDENT;
          C_RD_QUERY:   rmode_d = RM_QUERY;
          C_CLR_STATUS: begin
            err_prog_d = 1'b0; err_erase_d = 1'b0; err_lock_d = 1'b0;
            rmode_d = RM_ARRAY;
          end
          default: ;
        endcase
      end else begin
        case (seq_q)
          SQ_IDLE: begin
            case (cmd)
              C_RD_ARRAY:  rmode_d = RM_ARRAY;
              C_RD_STATUS: rmode_d = RM_STATUS;
              C_RD_IDENT:  rmode_d = RM_IDENT;
              C_RD_QUERY:  rmode_d = RM_QUERY;
              C_CLR_STATUS: begin
                err_prog_d = 1'b0; err_erase_d = 1'b0; err_lock_d = 1'b0;
                rmode_d = RM_ARRAY;
              end
              C_PROG_A, C_PROG_B: begin seq_d = SQ_PROG_DATA;  rmode_d = RM_STATUS; end
              C_ERASE:            begin seq_d = SQ_ERASE_CONF; rmode_d = RM_STATUS; end
              C_LOCK:             begin seq_d = SQ_LOCK_CONF;  rmode_d = RM_STATUS; end
              C_BUF: begin
                seq_d   = SQ_BUF_COUNT;
                rmode_d = RM_XSTAT;
                addr_d  = wr_addr;
              end
              default: ;
            endcase
          end
          SQ_PROG_DATA: begin
            seq_d = SQ_IDLE;
            if (lock_fail) begin
              err_prog_d = 1'b1; err_lock_d = 1'b1;
            end else begin
              launch = 1'b1; launch_kind = OP_PROG;
              opaddr_d = wr_addr; opdata_d = wr_data;
            end
          end
          SQ_ERASE_CONF: begin
            seq_d = SQ_IDLE;
            if (cmd != C_CONFIRM) begin
              err_prog_d = 1'b1; err_erase_d = 1'b1;
            end else if (lock_fail) begin
              err_erase_d = 1'b1; err_lock_d = 1'b1;
            end else begin
              launch = 1'b1; launch_kind = OP_ERASE; opaddr_d = wr_addr;
            end
          end
          SQ_LOCK_CONF: begin
            seq_d = SQ_IDLE;
            if (cmd == C_LOCK_SET)      lock_set = 1'b1;
            else if (cmd == C_CONFIRM)  lock_clr = 1'b1;
            else begin err_prog_d = 1'b1; err_erase_d = 1'b1; end
          end
          SQ_BUF_COUNT: begin
            if (cnt_val <= cnt_max) begin
              buf_start = 1'b1;
              seq_d     = SQ_BUF_DATA;
            end else begin
              seq_d = SQ_IDLE; rmode_d = RM_STATUS;
              err_prog_d = 1'b1; err_erase_d = 1'b1;
            end
          end
          SQ_BUF_DATA: begin
            buf_step = 1'b1;
            if (buf_last) seq_d = SQ_BUF_CONF;
          end
          SQ_BUF_CONF: begin
            seq_d = SQ_IDLE; rmode_d = RM_STATUS;
            if (cmd != C_CONFIRM) begin
              err_prog_d = 1'b1; err_erase_d = 1'b1;
            end else if (lock_fail) begin
              err_prog_d = 1'b1; err_lock_d = 1'b1;
            end else begin
              launch = 1'b1; launch_kind = OP_BUF; opaddr_d = addr_q;
            end
          end
          default: seq_d = SQ_IDLE;
        endcase
      end
    end
    if (launch) kind_d = launch_kind;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= SQ_IDLE;  rmode_q <= RM_ARRAY;  kind_q <= OP_PROG;  susp_q <= 1'b0;
      err_prog_q <= 1'b0;  err_erase_q <= 1'b0;  err_lock_q <= 1'b0;
      addr_q <= '0;  opaddr_q <= '0;  opdata_q <= '0;  start_q <= 1'b0;
    end else begin
      seq_q <= seq_d;  rmode_q <= rmode_d;  kind_q <= kind_d;  susp_q <= susp_d;
      err_prog_q <= err_prog_d;  err_erase_q <= err_erase_d;  err_lock_q <= err_lock_d;
      addr_q <= addr_d;  opaddr_q <= opaddr_d;  opdata_q <= opdata_d;  start_q <= launch;
    end
  end

  fcs_busy_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .load_erase(launch_kind == OP_ERASE), .hold(susp_q), .busy(busy_w));

  fcs_lock_bank #(.BLK_W(BLK_W)) u_locks (
    .clk(clk), .rst_n(rst_n), .set_en(lock_set),
    .set_blk(wr_addr[ADDR_W-1 -: BLK_W]), .clr_all(lock_clr),
    .chk_blk(chk_blk), .chk_locked(chk_locked),
    .rd_blk(rd_addr[ADDR_W-1 -: BLK_W]), .rd_locked(rd_locked));

  fcs_buf_ctrl #(.IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .start(buf_start), .n_in(cnt_val[IDX_W-1:0]),
    .step(buf_step), .din(wr_data), .last(buf_last), .n_out(buf_n),
    .we(buf_we), .widx(buf_idx), .wdata(buf_wdata));

  assign sr = {!busy_w || susp_q, susp_q && kind_q == OP_ERASE, err_erase_q, err_prog_q,
               1'b0, susp_q && kind_q != OP_ERASE, err_lock_q, 1'b0};

  always_comb begin
    rd_oe = running ? 16'h0080 : 16'hFFFF;
    if (running) rd_data = 16'h0000;
    else begin
      case (rmode_q)
        RM_STATUS: rd_data = {8'h00, sr};
        RM_IDENT:  rd_data = {15'h0000, rd_locked};
        RM_QUERY:  rd_data = query_rdata;
        RM_XSTAT:  rd_data = {8'h00, !busy_w, 7'h00};
        default:   rd_data = array_rdata;
      endcase
    end
  end

  assign op_start = start_q;
  assign op_kind  = kind_q;
  assign op_addr  = opaddr_q;
  assign op_data  = opdata_q;
  assign op_len   = buf_n;
  assign busy     = busy_w;

  AST_START_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |-> $past(wr_en)); // R4
  AST_CONFIRMED_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind != OP_PROG) |-> $past(wr_data[7:0] == C_CONFIRM)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_prog_q) || $fell(err_erase_q) || $fell(err_lock_q))
      |-> $past(wr_en && wr_data[7:0] == C_CLR_STATUS)); // R12
  AST_SUSP_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> $past(busy_w)); // R11

endmodule

// File: tb/sim_flash_cmd_seq.sv
`timescale 1ns/1ps
module sim_flash_cmd_seq;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 5;

  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1, wr_en = 1'b0, byte_mode = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] array_rdata = 16'hA5A5, query_rdata = 16'h5151;
  logic [15:0] rd_data, rd_oe, op_data, buf_wdata;
  logic op_start, buf_we, busy;
  logic [1:0] op_kind;
  logic [ADDR_W-1:0] op_addr;
  logic [IDX_W-1:0] op_len, buf_idx;

  always #2.5 clk = ~clk;

  flash_cmd_seq u0 (.*);

  int errs = 0, checks = 0, op_cnt = 0, buf_cnt = 0, buf_bad = 0;
  logic [1:0] l_kind; logic [ADDR_W-1:0] l_addr; logic [15:0] l_data, l_bdata;
  logic [IDX_W-1:0] l_len, l_idx, p_idx;
  bit done = 0;

  always @(posedge clk) begin
    if (op_start) begin
      op_cnt++; l_kind = op_kind; l_addr = op_addr; l_data = op_data; l_len = op_len;
    end
    if (buf_we) begin
      if (buf_idx != 0 && buf_idx != p_idx + 1'b1) buf_bad++;
      p_idx = buf_idx; l_idx = buf_idx; l_bdata = buf_wdata; buf_cnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {requirement number, command word, expected rd_data}
  localparam logic [39:0] TBL [14] = '{
    {8'd13, 16'h0070, 16'h0080},  // R13 status
    {8'd13, 16'h0098, 16'h5151},  // R13 query
    {8'd13, 16'h0090, 16'h0000},  // R13 identifier, block 0 unlocked
    {8'd13, 16'h00FF, 16'hA5A5},  // R13 array
    {8'd2,  16'h3470, 16'h0080},  // R2 upper byte ignored
    {8'd2,  16'hAB98, 16'h5151},  // R2
    {8'd2,  16'h77FF, 16'hA5A5},  // R2
    {8'd3,  16'h0033, 16'hA5A5},  // R3 reserved code
    {8'd3,  16'h00B0, 16'hA5A5},  // R3 suspend with nothing running
    {8'd3,  16'h00D0, 16'hA5A5},  // R3 lone confirm
    {8'd3,  16'h0001, 16'hA5A5},  // R3
    {8'd13, 16'h0070, 16'h0080},  // R13
    {8'd3,  16'h00C5, 16'h0080},  // R3 reserved keeps status mode
    {8'd12, 16'h0050, 16'hA5A5}   // R12 clear status selects array
  };

  task automatic buf_seq(input logic [ADDR_W-1:0] a, input int n, input logic bm,
                         input string tag);
    int c0, b0;
    c0 = op_cnt; b0 = buf_cnt; byte_mode = bm;
    wr(a, 16'h00E8);
    chk({tag, " buffer status"}, rd_data, 32'h0080);
    wr(a, 16'(n));
    for (int i = 0; i <= n; i++) wr(a + 12'(i), 16'h1000 + 16'(i));
    idle(1);
    chk({tag, " no launch before confirm"}, op_cnt, c0);
    chk({tag, " data cycles"}, buf_cnt - b0, n + 1);
    chk({tag, " last index"}, l_idx, n);
    chk({tag, " last data"}, l_bdata, 16'h1000 + 16'(n));
    wr(a, 16'h00D0);
    idle(1);
    chk({tag, " launch"}, op_cnt, c0 + 1);
    chk({tag, " kind/addr/len"}, {l_kind, l_addr, l_len}, {2'd1, a, IDX_W'(n)});
    byte_mode = 1'b0;
    idle(12);
  endtask

  initial begin
    int c0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1 rd_data", rd_data, 16'hA5A5);
    chk("R1 rd_oe", rd_oe, 16'hFFFF);
    chk("R1 busy/op_start", {busy, op_start}, 2'b00);
    wr(0, 16'h0070);
    chk("R1 status", rd_data, 16'h0080);

    for (int i = 0; i < 14; i++) begin
      wr(0, TBL[i][31:16]);
      chk($sformatf("R%0d table %0d", TBL[i][39:32], i), rd_data, TBL[i][15:0]);
    end

    // R4 with 40h, R10 masking
    c0 = op_cnt;
    wr(12'h010, 16'h0040); wr(12'h010, 16'h1234);
    chk("R10 oe mask", rd_oe, 16'h0080);
    chk("R10 data masked", rd_data, 16'h0000);
    idle(1);
    chk("R4 launch 40h", op_cnt, c0 + 1);
    chk("R4 kind/addr/data", {l_kind, l_addr, l_data}, {2'd0, 12'h010, 16'h1234});
    idle(9);
    chk("R10 done", {busy, rd_oe, rd_data}, {1'b0, 16'hFFFF, 16'h0080});
    // R4 with 10h
    wr(12'h020, 16'h0010); wr(12'h020, 16'hBEEF);
    idle(1);
    chk("R4 launch 10h", op_cnt, c0 + 2);
    chk("R4 addr/data 10h", {l_addr, l_data}, {12'h020, 16'hBEEF});
    idle(10);

    buf_seq(12'h100, 3, 1'b0, "R5 word");
    buf_seq(12'h200, 31, 1'b1, "R5 byte");
    buf_seq(12'h300, 15, 1'b0, "R5 word max");
    chk("R5 no index gaps", buf_bad, 0);

    // R6 abort on wrong confirm, R12 sticky then clear
    c0 = op_cnt;
    wr(12'h100, 16'h00E8); wr(12'h100, 16'h0001);
    wr(12'h100, 16'h1111); wr(12'h101, 16'h2222); wr(12'h100, 16'h00FF);
    idle(1);
    chk("R6 abort no launch", op_cnt, c0);
    chk("R6 abort status", rd_data, 16'h00B0);
    wr(0, 16'h00FF); wr(0, 16'h0070);
    chk("R12 errors sticky", rd_data, 16'h00B0);
    wr(0, 16'h0050);
    chk("R12 clear to array", rd_data, 16'hA5A5);
    wr(0, 16'h0070);
    chk("R12 cleared status", rd_data, 16'h0080);
    wr(12'h100, 16'h00E8); wr(12'h100, 16'h0010);
    chk("R6 word count 16 rejected", rd_data, 16'h00B0);
    wr(0, 16'h0050);
    byte_mode = 1'b1;
    wr(12'h100, 16'h00E8); wr(12'h100, 16'h0020);
    byte_mode = 1'b0;
    chk("R6 byte count 32 rejected", rd_data, 16'h00B0);
    wr(0, 16'h0050);

    // R7 erase
    c0 = op_cnt;
    wr(12'h400, 16'h0020); wr(12'h400, 16'h00FF);
    chk("R7 bad confirm", rd_data, 16'h00B0);
    wr(0, 16'h0050);
    wr(12'h400, 16'h0020); wr(12'h400, 16'h00D0);
    idle(1);
    chk("R7 erase launch", {op_cnt, l_kind, l_addr}, {c0 + 1, 2'd2, 12'h400});
    idle(12);
    chk("R7 erase still busy", busy, 1'b1);
    idle(10);
    chk("R7 erase done", {busy, rd_data}, {1'b0, 16'h0080});

    // R8 locks
    wr(12'h800, 16'h0060); wr(12'h800, 16'h0001);
    wr(0, 16'h0090);
    rd_addr = 12'h800; idle(1);
    chk("R8 ident locked", rd_data, 16'h0001);
    rd_addr = 12'h000; idle(1);
    chk("R8 ident other", rd_data, 16'h0000);
    c0 = op_cnt;
    wr(12'h810, 16'h0040); wr(12'h810, 16'h5555);
    idle(1);
    chk("R8 program rejected", {op_cnt, rd_data}, {c0, 16'h0092});
    wr(0, 16'h0050);
    wr(12'h800, 16'h0020); wr(12'h800, 16'h00D0);
    idle(1);
    chk("R8 erase rejected", {op_cnt, rd_data}, {c0, 16'h00A2});
    wr(0, 16'h0050);
    wp_n = 1'b0;
    wr(12'h810, 16'h0040); wr(12'h810, 16'h6666);
    idle(1);
    chk("R8 protect low overrides", op_cnt, c0 + 1);
    idle(10);
    wp_n = 1'b1;

    // R9 clear all
    wr(12'h400, 16'h0060); wr(12'h400, 16'h0001);
    wr(12'hC00, 16'h0060); wr(12'hC00, 16'h0001);
    wr(0, 16'h0090);
    rd_addr = 12'h400; idle(1);
    chk("R9 block1 locked", rd_data, 16'h0001);
    wr(0, 16'h0060); wr(0, 16'h00D0); wr(0, 16'h0090);
    for (int b = 0; b < 4; b++) begin
      rd_addr = 12'(b * 1024); idle(1);
      chk($sformatf("R9 block %0d cleared", b), rd_data, 16'h0000);
    end
    rd_addr = 0;

    // R11 suspend of program
    wr(12'h010, 16'h0040); wr(12'h010, 16'h7777);
    wr(0, 16'h00B0);
    chk("R11 program suspended", {rd_oe, rd_data}, {16'hFFFF, 16'h0084});
    idle(20);
    chk("R11 time frozen", {busy, rd_data}, {1'b1, 16'h0084});
    wr(0, 16'h00D0);
    chk("R11 resumed masked", rd_oe, 16'h0080);
    idle(10);
    chk("R11 program finished", {busy, rd_data}, {1'b0, 16'h0080});
    // suspend of buffered write
    wr(12'h100, 16'h00E8); wr(12'h100, 16'h0000); wr(12'h100, 16'h4242);
    wr(12'h100, 16'h00D0); wr(0, 16'h00B0);
    chk("R11 buffer suspended", rd_data, 16'h0084);
    wr(0, 16'h00D0); idle(10);
    // suspend of erase
    wr(0, 16'h0020); wr(0, 16'h00D0); wr(0, 16'h00B0);
    chk("R11 erase suspended", rd_data, 16'h00C0);
    wr(0, 16'h00D0); idle(22);
    chk("R11 erase finished", {busy, rd_data}, {1'b0, 16'h0080});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule